// File: doc/BRIEF.md
# Dual-Clock Bidirectional Mailbox Pair

This block sits beside a two-clock bidirectional FIFO and offers a direct side channel of one word in each direction. Port A, in clock domain A, posts a word into the first mailbox, and Port B, in clock domain B, collects it. The second mailbox carries a word the other way, from B to A. Each mailbox has a "free" flag that lives in the writer's clock domain. The flag is high while the mailbox can take a word. It goes low once a word has been posted, and it stays low until the reader has collected the word and that release has crossed back into the writer's domain.

Each crossing uses a toggle signal and a synchroniser chain. The posted word is held stable while it is in flight, so the reader samples settled data. On each port, the mailbox-select input also steers the read-data output between the mailbox contents and the FIFO read data that is fed in from outside. Each port also provides an output-enable whose read polarity is opposite on the two ports.

Top module: `bimbx_top`

## Requirements
- R1: A clock-A edge with `a_en_i`=1, `a_mbx_i`=1 and `a_wr_i`=1, taken while `a_mbx_free_o`=1, loads `a_din_i` into mailbox one, and `a_mbx_free_o` reads 0 after that edge. Mailbox two behaves the same way from port B: `b_en_i`=1, `b_mbx_i`=1, `b_rd_i`=0, with `b_mbx_free_o`.
- R2: A mailbox write taken while the writer's free flag is 0 is ignored. The word delivered to the reader is still the first word.
- R3: A reader edge with enable=1, mailbox select=1 and read chosen (`b_rd_i`=1 on B, `a_wr_i`=0 on A), taken while a message is pending, releases that mailbox. The writer's free flag returns to 1 within SYNC_STAGES+3 writer clock cycles.
- R4: Mailbox two carries a word from port B to port A with the same rules as R1 to R3, with the two clock domains swapped.
- R5: A mailbox read taken while no message is pending returns the last written word unchanged and leaves the writer's free flag at 1.
- R6: `rst_ni`=0 (full reset) or `prst_ni`=0 (partial reset) forces both free flags to 1 and discards any pending message.
- R7: `b_dout_o` equals mailbox one when `b_mbx_i`=1 and equals `b_fifo_i` when `b_mbx_i`=0. `a_dout_o` equals mailbox two when `a_mbx_i`=1 and equals `a_fifo_i` when `a_mbx_i`=0.
- R8: `a_oe_o` is 1 exactly when `a_wr_i`=0. `b_oe_o` is 1 exactly when `b_rd_i`=1.
- R9: With no read on the reader side, a writer's free flag stays at 0 indefinitely after a post.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Port A clock |
| clk_b_i | input | 1 | Port B clock |
| rst_ni | input | 1 | Full reset, active low, asynchronous |
| prst_ni | input | 1 | Partial reset, active low, asynchronous |
| a_en_i | input | 1 | Port A access enable |
| a_wr_i | input | 1 | Port A direction: 1 = write, 0 = read |
| a_mbx_i | input | 1 | Port A mailbox select |
| a_din_i | input | DATA_W | Port A write data |
| a_fifo_i | input | DATA_W | FIFO read data for Port A |
| a_dout_o | output | DATA_W | Port A read data |
| a_oe_o | output | 1 | Port A output enable |
| a_mbx_free_o | output | 1 | Mailbox one free flag (clock A) |
| b_en_i | input | 1 | Port B access enable |
| b_rd_i | input | 1 | Port B direction: 1 = read, 0 = write |
| b_mbx_i | input | 1 | Port B mailbox select |
| b_din_i | input | DATA_W | Port B write data |
| b_fifo_i | input | DATA_W | FIFO read data for Port B |
| b_dout_o | output | DATA_W | Port B read data |
| b_oe_o | output | 1 | Port B output enable |
| b_mbx_free_o | output | 1 | Mailbox two free flag (clock B) |

## Verification
The bench builds the block with its default parameters: a 36-bit word and a two-flop synchroniser. Clock A and clock B run at unrelated periods, so the toggle crossings are exercised with a drifting phase relationship. The full 36-bit width lets patterns that differ in the top and bottom bits be told apart after each crossing. The short synchroniser keeps the release latency in R3 small enough for the bench to bound it tightly.

// File: rtl/bimbx_pkg.sv
package bimbx_pkg;
  localparam int unsigned DEF_DATA_W = 36;
  localparam int unsigned DEF_SYNC_N = 2;
endpackage

// File: rtl/bimbx_sync.sv
module bimbx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/bimbx_chan.sv
module bimbx_chan #(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              wclk_i,
  input  logic              wrst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              free_o,
  input  logic              rclk_i,
  input  logic              rrst_ni,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q;
  logic wr_tog_q, rd_tog_q, ack_s, seen_s, pend_r;

  // writer domain
  bimbx_sync #(.STAGES(SYNC_N)) u_ack_sync (
    .clk_i(wclk_i), .rst_ni(wrst_ni), .d_i(rd_tog_q), .q_o(ack_s)
  );

  assign free_o = (wr_tog_q == ack_s);

  always_ff @(posedge wclk_i or negedge wrst_ni)
    if (!wrst_ni) begin
      mem_q    <= '0;
      wr_tog_q <= 1'b0;
    end else if (wr_i && free_o) begin
      mem_q    <= wdata_i;
      wr_tog_q <= ~wr_tog_q;
    end

  // reader domain
  bimbx_sync #(.STAGES(SYNC_N)) u_req_sync (
    .clk_i(rclk_i), .rst_ni(rrst_ni), .d_i(wr_tog_q), .q_o(seen_s)
  );

  assign pend_r = (seen_s != rd_tog_q);

  always_ff @(posedge rclk_i or negedge rrst_ni)
    if (!rrst_ni)            rd_tog_q <= 1'b0;
    else if (rd_i && pend_r) rd_tog_q <= ~rd_tog_q;

  // word is held stable while in flight, so the reader samples settled data
  assign rdata_o = mem_q;

  a_r1_post_claims: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    (wr_i && free_o) |=> !free_o);
  a_r2_blocked_write: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    (wr_i && !free_o) |=> $stable(mem_q));
  a_r3_read_releases: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    (rd_i && pend_r) |=> !pend_r);
  a_r5_empty_read: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    (rd_i && !pend_r) |=> $stable(rd_tog_q));
endmodule

// File: rtl/bimbx_top.sv
module bimbx_top
  import bimbx_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned SYNC_N = DEF_SYNC_N
) (
  input  logic              clk_a_i,
  input  logic              clk_b_i,
  input  logic              rst_ni,
  input  logic              prst_ni,
  input  logic              a_en_i,
  input  logic              a_wr_i,
  input  logic              a_mbx_i,
  input  logic [DATA_W-1:0] a_din_i,
  input  logic [DATA_W-1:0] a_fifo_i,
  output logic [DATA_W-1:0] a_dout_o,
  output logic              a_oe_o,
  output logic              a_mbx_free_o,
  input  logic              b_en_i,
  input  logic              b_rd_i,
  input  logic              b_mbx_i,
  input  logic [DATA_W-1:0] b_din_i,
  input  logic [DATA_W-1:0] b_fifo_i,
  output logic [DATA_W-1:0] b_dout_o,
  output logic              b_oe_o,
  output logic              b_mbx_free_o
);
  logic              rst_all_n;
  logic              a_mb_wr, a_mb_rd, b_mb_wr, b_mb_rd;
  logic [DATA_W-1:0] mail1_w, mail2_w;

  // either reset clears both directions
  assign rst_all_n = rst_ni & prst_ni;

  assign a_mb_wr = a_en_i & a_mbx_i &  a_wr_i;
  assign a_mb_rd = a_en_i & a_mbx_i & ~a_wr_i;
  assign b_mb_wr = b_en_i & b_mbx_i & ~b_rd_i;
  assign b_mb_rd = b_en_i & b_mbx_i &  b_rd_i;

  bimbx_chan #(.DATA_W(DATA_W), .SYNC_N(SYNC_N)) u_mail1 (
    .wclk_i(clk_a_i), .wrst_ni(rst_all_n), .wr_i(a_mb_wr), .wdata_i(a_din_i),
    .free_o(a_mbx_free_o),
    .rclk_i(clk_b_i), .rrst_ni(rst_all_n), .rd_i(b_mb_rd), .rdata_o(mail1_w)
  );

  bimbx_chan #(.DATA_W(DATA_W), .SYNC_N(SYNC_N)) u_mail2 (
    .wclk_i(clk_b_i), .wrst_ni(rst_all_n), .wr_i(b_mb_wr), .wdata_i(b_din_i),
    .free_o(b_mbx_free_o),
    .rclk_i(clk_a_i), .rrst_ni(rst_all_n), .rd_i(a_mb_rd), .rdata_o(mail2_w)
  );

  assign a_dout_o = a_mbx_i ? mail2_w : a_fifo_i;
  assign b_dout_o = b_mbx_i ? mail1_w : b_fifo_i;
  assign a_oe_o   = ~a_wr_i;
  assign b_oe_o   =  b_rd_i;

  a_r6_reset_frees: assert property (@(posedge clk_a_i)
    !rst_all_n |-> (a_mbx_free_o && b_mbx_free_o));
endmodule

// File: tb/bimbx_top_tb_top.sv
module bimbx_top_tb_top;
  localparam int W = 36;
  logic clk_a = 0, clk_b = 0, rst_n = 0, prst_n = 1;
  logic a_en = 0, a_wr = 0, a_mbx = 0, b_en = 0, b_rd = 0, b_mbx = 0;
  logic [W-1:0] a_din = '0, a_fifo = '0, b_din = '0, b_fifo = '0;
  logic [W-1:0] a_dout, b_dout;
  logic a_oe, b_oe, a_free, b_free;
  int n_run = 0, n_fail = 0;
  logic [W-1:0] q1[$], q2[$];

  always #2.5 clk_a = ~clk_a;
  always #3.7 clk_b = ~clk_b;

  bimbx_top dut_i (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_n), .prst_ni(prst_n),
    .a_en_i(a_en), .a_wr_i(a_wr), .a_mbx_i(a_mbx), .a_din_i(a_din), .a_fifo_i(a_fifo),
    .a_dout_o(a_dout), .a_oe_o(a_oe), .a_mbx_free_o(a_free),
    .b_en_i(b_en), .b_rd_i(b_rd), .b_mbx_i(b_mbx), .b_din_i(b_din), .b_fifo_i(b_fifo),
    .b_dout_o(b_dout), .b_oe_o(b_oe), .b_mbx_free_o(b_free)
  );

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_a(input int n); for (int i = 0; i < n; i++) @(posedge clk_a); #1; endtask
  task automatic wait_b(input int n); for (int i = 0; i < n; i++) @(posedge clk_b); #1; endtask

  // driver: post on A into mailbox one; push expectation only when accepted
  task automatic post_a(input logic [W-1:0] v);
    bit acc;
    @(posedge clk_a); #1;
    acc = a_free;
    a_en = 1; a_wr = 1; a_mbx = 1; a_din = v;
    @(posedge clk_a); #1;
    a_en = 0; a_mbx = 0;
    if (acc) q1.push_back(v);
  endtask

  task automatic post_b(input logic [W-1:0] v);
    bit acc;
    @(posedge clk_b); #1;
    acc = b_free;
    b_en = 1; b_rd = 0; b_mbx = 1; b_din = v;
    @(posedge clk_b); #1;
    b_en = 0; b_mbx = 0; b_rd = 1;
    if (acc) q2.push_back(v);
  endtask

  // monitor: collect on B, compare against queue
  task automatic fetch_b(input string tag);
    logic [W-1:0] e;
    wait_b(6);
    e = (q1.size() > 0) ? q1.pop_front() : '0;
    b_en = 1; b_rd = 1; b_mbx = 1; #0.1;
    chk(b_dout === e, tag, b_dout, e);
    @(posedge clk_b); #1;
    b_en = 0; b_mbx = 0;
  endtask

  task automatic fetch_a(input string tag);
    logic [W-1:0] e;
    wait_a(8);
    e = (q2.size() > 0) ? q2.pop_front() : '0;
    a_en = 1; a_wr = 0; a_mbx = 1; #0.1;
    chk(a_dout === e, tag, a_dout, e);
    @(posedge clk_a); #1;
    a_en = 0; a_mbx = 0;
  endtask

  bit done = 0;
  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    b_rd = 1;
    #20 rst_n = 1;
    wait_a(2);
    chk(a_free === 1'b1, "R6 reset free A", a_free, 1);
    chk(b_free === 1'b1, "R6 reset free B", b_free, 1);

    // R1 post, R9 hold without read
    post_a(36'hA_5A5A_0001);
    chk(a_free === 1'b0, "R1 flag low after post", a_free, 0);
    wait_a(20);
    chk(a_free === 1'b0, "R9 flag held without read", a_free, 0);
    // R2 blocked write
    post_a(36'h0_DEAD_BEEF);
    fetch_b("R1/R2 mailbox one data");
    wait_a(2 + 3);
    chk(a_free === 1'b1, "R3 flag released", a_free, 1);

    // R5 empty read: stale data, flag unaffected
    b_en = 1; b_rd = 1; b_mbx = 1; #0.1;
    chk(b_dout === 36'hA_5A5A_0001, "R5 stale data", b_dout, 36'hA_5A5A_0001);
    @(posedge clk_b); #1; b_en = 0; b_mbx = 0;
    wait_a(10);
    chk(a_free === 1'b1, "R5 flag unchanged", a_free, 1);

    // second pattern through mailbox one
    post_a(36'hF_0000_000F);
    fetch_b("R1 pattern two");

    // R4 mailbox two
    post_b(36'h1_2345_6789);
    chk(b_free === 1'b0, "R4 flag low after post", b_free, 0);
    post_b(36'h3_3333_3333);
    fetch_a("R4 mailbox two data");
    wait_b(2 + 3);
    chk(b_free === 1'b1, "R4 flag released", b_free, 1);

    // R7 mux and R8 enables
    a_fifo = 36'h5_5555_AAAA; b_fifo = 36'hC_CCCC_3333;
    a_mbx = 0; b_mbx = 0; a_wr = 0; b_rd = 1; #1;
    chk(a_dout === a_fifo, "R7 A fifo path", a_dout, a_fifo);
    chk(b_dout === b_fifo, "R7 B fifo path", b_dout, b_fifo);
    b_mbx = 1; #1;
    chk(b_dout === 36'hF_0000_000F, "R7 B mailbox path", b_dout, 36'hF_0000_000F);
    b_mbx = 0;
    chk(a_oe === 1'b1, "R8 A oe on read", a_oe, 1);
    chk(b_oe === 1'b1, "R8 B oe on read", b_oe, 1);
    a_wr = 1; b_rd = 0; #1;
    chk(a_oe === 1'b0, "R8 A oe on write", a_oe, 0);
    chk(b_oe === 1'b0, "R8 B oe on write", b_oe, 0);
    b_rd = 1; a_wr = 0;

    // R6 partial reset
    post_a(36'h7_7777_7777);
    post_b(36'h8_8888_8888);
    q1.delete(); q2.delete();
    wait_a(2);
    chk(a_free === 1'b0, "R6 pre partial reset A", a_free, 0);
    prst_n = 0; #1;
    chk(a_free === 1'b1, "R6 partial reset A", a_free, 1);
    chk(b_free === 1'b1, "R6 partial reset B", b_free, 1);
    #9 prst_n = 1;
    // R6 full reset
    post_a(36'h9_9999_9999);
    q1.delete();
    rst_n = 0; #1;
    chk(a_free === 1'b1, "R6 full reset A", a_free, 1);
    #9 rst_n = 1;
    wait_b(6);
    b_en = 1; b_rd = 1; b_mbx = 1; @(posedge clk_b); #1; b_en = 0; b_mbx = 0;
    wait_a(10);
    chk(a_free === 1'b1, "R6 no stale message after reset", a_free, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule